// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block turns the 5-bit register field of an instruction into a location in a banked data memory and serves that location through one read/write port. The memory holds sixteen numbered banks and one global bank, each of sixteen 8-bit registers. An 8-bit select register, itself stored at global location 4, supplies the bank for semi-direct accesses and the whole pointer for indirect accesses.

The field value picks one of three ways to form the address. Zero means "use the pointer". Values 1 to 15 address the global bank directly. Values 16 to 31 join the upper nibble of the select register with the low four field bits. The select register can be replaced as a byte, have its three bank bits (6:4) replaced by a bank command, or have its top bit set by itself.

Top module: `bankreg_mapper`

## Requirements
- R1: After reset the select register and every stored register hold 0x00, so a field of 0x04 reads 0x00 and a field of 0x00 gives an invalid, zero address.
- R2: A field in 0x01..0x0F yields physical address {1'b1, 4'h0, field[3:0]} with valid high, whatever the select register holds. The physical address is 9 bits: bit 8 flags the global bank, bits 7:4 the bank, bits 3:0 the register.
- R3: A field in 0x10..0x1F yields {1'b0, sel[7:4], field[3:0]}, so the global bank is never reached this way.
- R4: A field of 0x00 with a select value whose upper nibble is nonzero yields {1'b0, sel[7:4], sel[3:0]}; with upper nibble zero and low nibble nonzero it yields {1'b1, 4'h0, sel[3:0]}, so bank 0 is never reached this way.
- R5: A field of 0x00 while the select register is 0x00 gives valid low, address 0, read data 0x00, and a write is dropped: no stored register and not the select register change.
- R6: Read data follows the computed address within the same cycle; a write with write enable high takes effect at the next rising clock edge.
- R7: Global location 4, reached directly or indirectly, reads back the select register, and a write there replaces all eight of its bits.
- R8: A bank command replaces select bits 6:4 with its 3-bit value and leaves bits 7 and 3:0 as they were.
- R9: The top-bit set command forces select bit 7 to 1 and leaves bits 6:0 as they were.
- R10: In one cycle a byte write to the select register overrides a bank command and a top-bit set; a bank command and a top-bit set in the same cycle both apply.
- R11: Global register n and bank 0 register n are separate storage: a write to one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fld_i | input | 5 | Register field from the instruction |
| wr_en_i | input | 1 | Write the addressed register at the next edge |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the addressed register |
| bank_cmd_i | input | 1 | Replace the select register's bank bits |
| bank_val_i | input | 3 | New value for select bits 6:4 |
| msb_set_i | input | 1 | Force select bit 7 to 1 |
| paddr_o | output | 9 | Physical address: global flag, bank, register |
| paddr_valid_o | output | 1 | Low when an indirect access has a zero pointer |

## Verification
The address, its valid flag and the read data depend on no register, so they are due in the cycle the field is applied; any write, bank command or top-bit set shows one rising edge later. The bench drives each operation just after a falling edge, pushes the expected address, valid flag and read data taken from its own model of the state before the coming edge, and the monitor compares them a quarter period later, before that edge. Effects of writes are then checked by a later operation that reads the affected location.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  // Widths of the register file and the instruction field.
  parameter int DW = 8;   // register width
  parameter int BW = 4;   // bank number width
  parameter int IW = 4;   // register index width
  localparam int FW    = IW + 1;       // instruction field width
  localparam int NBANK = 1 << BW;
  localparam int NIDX  = 1 << IW;
  localparam int ROWS  = NBANK + 1;    // numbered banks plus the global bank
  localparam int PW    = 1 + BW + IW;  // physical address width
  localparam logic [IW-1:0] SEL_IDX = IW'(4); // global slot of the select register

  typedef enum logic [1:0] {
    AM_PTR  = 2'd0,
    AM_GLB  = 2'd1,
    AM_BANK = 2'd2
  } amode_e;

  typedef struct packed {
    logic          glb;
    logic [BW-1:0] bank;
    logic [IW-1:0] idx;
  } paddr_t;

  function automatic amode_e mode_of(input logic [FW-1:0] fld);
    if (fld == '0)         return AM_PTR;
    else if (fld[FW-1])    return AM_BANK;
    else                   return AM_GLB;
  endfunction

  function automatic logic ptr_null(input amode_e m, input logic [DW-1:0] sel);
    return (m == AM_PTR) && (sel == '0);
  endfunction

  function automatic paddr_t map_addr(input amode_e m, input logic [FW-1:0] fld,
                                      input logic [DW-1:0] sel);
    paddr_t p;
    p = '0;
    case (m)
      AM_GLB: begin
        p.glb = 1'b1;
        p.idx = fld[IW-1:0];
      end
      AM_BANK: begin
        p.bank = sel[DW-1 -: BW];
        p.idx  = fld[IW-1:0];
      end
      default: begin
        if (sel == '0) begin
          p = '0;
        end else if (sel[DW-1 -: BW] == '0) begin
          p.glb = 1'b1;
          p.idx = sel[IW-1:0];
        end else begin
          p.bank = sel[DW-1 -: BW];
          p.idx  = sel[IW-1:0];
        end
      end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bankreg_decode.sv
module bankreg_decode
  import bankreg_pkg::*;
(
  input  logic [FW-1:0] fld,
  input  logic [DW-1:0] sel,
  output amode_e        mode,
  output paddr_t        paddr,
  output logic          valid
);
  always_comb begin
    mode  = mode_of(fld);
    paddr = map_addr(mode, fld, sel);
    valid = !ptr_null(mode, sel);
  end
endmodule

// File: rtl/bankreg_selreg.sv
module bankreg_selreg
  import bankreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_wr,
  input  logic [DW-1:0] byte_data,
  input  logic          bank_cmd,
  input  logic [BW-2:0] bank_val,
  input  logic          msb_set,
  output logic [DW-1:0] sel_q
);
  localparam int MSB = DW - 1;
  localparam int BHI = DW - 2;
  localparam int BLO = DW - BW;

  logic [DW-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (msb_set)  sel_d[MSB] = 1'b1;
    if (bank_cmd) sel_d[BHI:BLO] = bank_val;
    if (byte_wr)  sel_d = byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  // R8: a bank command alone leaves bit 7 and the low nibble untouched
  a_r8_bank_cmd_partial: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_cmd && !byte_wr && !msb_set) |=>
      (sel_q[MSB] == $past(sel_q[MSB])) && (sel_q[IW-1:0] == $past(sel_q[IW-1:0]))
      && (sel_q[BHI:BLO] == $past(bank_val)));

  // R9: the top-bit set alone raises bit 7 and keeps the rest
  a_r9_msb_set_only: assert property (@(posedge clk) disable iff (!rst_n)
    (msb_set && !byte_wr && !bank_cmd) |=>
      sel_q[MSB] && (sel_q[BHI:0] == $past(sel_q[BHI:0])));

  // R10: a byte write wins over both partial updates
  a_r10_byte_wins: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> sel_q == $past(byte_data));
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  paddr_t        addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int RW = $clog2(ROWS);

  logic [DW-1:0] mem [ROWS][NIDX];
  logic [RW-1:0] row;

  // The global bank occupies the last row, after the numbered banks.
  assign row   = addr.glb ? RW'(NBANK) : RW'(addr.bank);
  assign rdata = mem[row][addr.idx];

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NIDX; i++) mem[r][i] <= '0;
        end else if (we && (row == RW'(r))) begin
          mem[r][addr.idx] <= wdata;
        end
      end
    end
  endgenerate

  // R6: a write lands by the next edge at the same location
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $stable(addr)) |=> (rdata == $past(wdata)) || !$stable(addr));
endmodule

// File: rtl/bankreg_mapper.sv
module bankreg_mapper
  import bankreg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    fld_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  output logic [7:0]    rd_data_o,
  input  logic          bank_cmd_i,
  input  logic [2:0]    bank_val_i,
  input  logic          msb_set_i,
  output logic [8:0]    paddr_o,
  output logic          paddr_valid_o
);
  amode_e        mode;
  paddr_t        paddr;
  logic          valid;
  logic [DW-1:0] sel_q;
  logic [DW-1:0] store_rd;
  logic          hits_sel;   // access lands on the select register
  logic          sel_wr;     // byte write into the select register
  logic          store_we;   // write into the array

  bankreg_decode u_dec (
    .fld   (fld_i),
    .sel   (sel_q),
    .mode  (mode),
    .paddr (paddr),
    .valid (valid)
  );

  assign hits_sel = valid && paddr.glb && (paddr.idx == SEL_IDX);
  assign sel_wr   = wr_en_i && hits_sel;
  assign store_we = wr_en_i && valid && !hits_sel;

  bankreg_selreg u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_wr   (sel_wr),
    .byte_data (wr_data_i),
    .bank_cmd  (bank_cmd_i),
    .bank_val  (bank_val_i),
    .msb_set   (msb_set_i),
    .sel_q     (sel_q)
  );

  bankreg_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .addr  (paddr),
    .wdata (wr_data_i),
    .rdata (store_rd)
  );

  always_comb begin
    if (!valid)        rd_data_o = '0;
    else if (hits_sel) rd_data_o = sel_q;
    else               rd_data_o = store_rd;
  end

  assign paddr_o       = paddr;
  assign paddr_valid_o = valid;

  // R2: direct fields always reach the global bank at the field index
  a_r2_direct_global: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_i != 5'd0 && !fld_i[4]) |-> (paddr_o == {1'b1, 4'h0, fld_i[3:0]}) && paddr_valid_o);

  // R3: semi-direct fields never reach the global bank
  a_r3_semi_no_global: assert property (@(posedge clk) disable iff (!rst_n)
    fld_i[4] |-> !paddr_o[8] && (paddr_o[7:4] == sel_q[7:4]));

  // R4: indirect accesses never reach bank 0 of the numbered banks
  a_r4_ptr_no_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_i == 5'd0 && paddr_valid_o) |-> (paddr_o[8] || paddr_o[7:4] != 4'h0));

  // R5: a write through a null pointer leaves the select register alone
  a_r5_null_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !paddr_valid_o && !bank_cmd_i && !msb_set_i) |=> $stable(sel_q));

  // R5: a null access reads zero
  a_r5_null_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !paddr_valid_o |-> (rd_data_o == 8'h00) && (paddr_o == 9'h000));

  // R7: a direct write to global slot 4 replaces the select register
  a_r7_sel_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && fld_i == 5'd4) |=> sel_q == $past(wr_data_i));
endmodule

// File: tb/bankreg_mapper_bench.sv
module bankreg_mapper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fld = '0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       bc = 1'b0;
  logic [2:0] bv = '0;
  logic       ms = 1'b0;
  logic [8:0] pa;
  logic       pv;

  always #10 clk = ~clk; // 50 MHz

  bankreg_mapper u_bankreg_mapper (
    .clk(clk), .rst_n(rst_n), .fld_i(fld), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd), .bank_cmd_i(bc), .bank_val_i(bv), .msb_set_i(ms),
    .paddr_o(pa), .paddr_valid_o(pv)
  );

  typedef struct {
    logic [8:0] pa;
    logic       pv;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model: flat array, numbered banks at 0..255, global bank at 256..271.
  logic [7:0] m_mem [272];
  logic [7:0] m_sel;

  task automatic op(input logic [4:0] f, input logic w, input logic [7:0] d,
                    input logic b, input logic [2:0] v, input logic s, input string tag);
    exp_t e;
    int   loc;
    logic [7:0] nsel;
    @(negedge clk);
    fld = f; we = w; wd = d; bc = b; bv = v; ms = s;
    e.tag = tag;
    e.pv  = 1'b1;
    if (f == 0) begin
      if (m_sel == 0) begin e.pv = 1'b0; loc = 0; end
      else if (m_sel < 16) loc = 256 + m_sel;
      else loc = m_sel;
    end else if (f < 16) loc = 256 + f;
    else loc = (m_sel / 16) * 16 + (f % 16);
    e.pa = e.pv ? 9'(loc) : 9'h000;
    if (!e.pv)            e.rd = 8'h00;
    else if (loc == 260)  e.rd = m_sel;
    else                  e.rd = m_mem[loc];
    q.push_back(e);
    nsel = m_sel;
    if (s) nsel = nsel | 8'h80;
    if (b) nsel = (nsel & 8'h8F) | {1'b0, v, 4'h0};
    if (w && e.pv) begin
      if (loc == 260) nsel = d;
      else m_mem[loc] = d;
    end
    m_sel = nsel;
  endtask

  task automatic rd_op(input logic [4:0] f, input string tag);
    op(f, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, tag);
  endtask

  task automatic wr_op(input logic [4:0] f, input logic [7:0] d, input string tag);
    op(f, 1'b1, d, 1'b0, 3'd0, 1'b0, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [8:0] act, input logic [8:0] exv);
    checks++;
    if (act !== exv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exv);
    end
  endtask

  // Monitor: compares a quarter period after each falling edge, before the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "paddr", pa, e.pa);
        cmp(e.tag, "valid", {8'h00, pv}, {8'h00, e.pv});
        cmp(e.tag, "rdata", {1'b0, rd}, {1'b0, e.rd});
      end
    end
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 272; i++) m_mem[i] = 8'h00;
    m_sel = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_op(5'h00, "R1 null at reset");
    rd_op(5'h04, "R1 select reads zero");
    rd_op(5'h13, "R1 bank0 reads zero");
    // R2 / R6 direct write then read
    wr_op(5'h05, 8'hA5, "R6 direct write");
    rd_op(5'h05, "R2 direct read");
    // R7 select register mapped
    wr_op(5'h04, 8'h30, "R7 byte write");
    rd_op(5'h04, "R7 read back");
    // R3 semi-direct
    wr_op(5'h15, 8'h3C, "R3 semi write");
    rd_op(5'h15, "R3 semi read");
    rd_op(5'h05, "R2 direct ignores select");
    // R4 indirect into a numbered bank
    wr_op(5'h04, 8'h35, "R7 set pointer");
    rd_op(5'h00, "R4 pointer to bank 3");
    // R4 indirect into the global bank
    wr_op(5'h04, 8'h07, "R7 set pointer");
    wr_op(5'h00, 8'h77, "R4 write global 7 by pointer");
    rd_op(5'h07, "R4 global 7 via direct");
    wr_op(5'h04, 8'h05, "R7 set pointer");
    rd_op(5'h00, "R4 pointer to global 5");
    // R8 bank command
    op(5'h01, 1'b0, 8'h00, 1'b1, 3'd5, 1'b0, "R8 bank cmd");
    rd_op(5'h04, "R8 result 0x55");
    wr_op(5'h04, 8'hA3, "R7 set pointer");
    op(5'h01, 1'b0, 8'h00, 1'b1, 3'd7, 1'b0, "R8 bank cmd keeps bit7");
    rd_op(5'h04, "R8 result 0xF3");
    // R9 top-bit set
    wr_op(5'h04, 8'h25, "R7 set pointer");
    op(5'h01, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1, "R9 msb set");
    rd_op(5'h04, "R9 result 0xA5");
    // R10 priority and combination
    op(5'h04, 1'b1, 8'h12, 1'b1, 3'd6, 1'b1, "R10 byte write wins");
    rd_op(5'h04, "R10 result 0x12");
    op(5'h02, 1'b0, 8'h00, 1'b1, 3'd3, 1'b1, "R10 both partial");
    rd_op(5'h04, "R10 result 0xB2");
    // R7 select register written through the pointer
    wr_op(5'h04, 8'h04, "R7 point at select");
    wr_op(5'h00, 8'h66, "R7 write by pointer");
    rd_op(5'h04, "R7 result 0x66");
    // R5 null pointer
    wr_op(5'h04, 8'h00, "R7 clear pointer");
    wr_op(5'h00, 8'h99, "R5 null write");
    rd_op(5'h04, "R5 select unchanged");
    rd_op(5'h05, "R5 global 5 unchanged");
    rd_op(5'h07, "R5 global 7 unchanged");
    rd_op(5'h10, "R5 bank0 slot 0 unchanged");
    // R11 global n and bank 0 n are separate
    rd_op(5'h15, "R11 bank0 5 separate");
    wr_op(5'h15, 8'h5B, "R11 write bank0 5");
    rd_op(5'h05, "R11 global 5 kept");
    rd_op(5'h15, "R11 bank0 5 written");
    @(negedge clk);
    fld = '0; we = 1'b0; bc = 1'b0; ms = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule